// File: doc/BRIEF.md
# Ones'-Complement Accumulator Adder/Subtractor with Positive-Overflow Tally

This block is the arithmetic stage of an accumulator datapath that works on signed words in ones'-complement form. Each accepted request carries the current accumulator value, an operand word and an operation select. The block returns the updated accumulator value. Addition and subtraction share one adder. A subtract request routes the bitwise-inverted operand into that adder in place of the operand itself, so a subtract always gives the same result as adding the inverted operand. The carry out of the sign position is fed back into the least significant position (end-around carry).

Whenever an accepted operation ends in a positive overflow, a wrapping tally is incremented. A positive overflow means that both adder inputs have a clear sign bit and the sum has its sign bit set. A negative overflow, where two negative inputs give a positive sum, leaves the tally alone. Requests arrive on a valid/ready input. Results leave on a valid/ready output held in a single register. The input is ready when that register is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result register holds its value and the input is back-pressured. The tally is a plain status output.

Top module: `oc_accum_unit`

## Requirements
- R1: On an accepted request with `req_sub` = 0, the next `res_acc` equals `req_acc` + `req_opnd` in ones' complement: the 15-bit sum plus its carry out of bit 14 added back at bit 0.
- R2: On an accepted request with `req_sub` = 1, the next `res_acc` equals `req_acc` + (~`req_opnd`), computed with the same end-around-carry rule.
- R3: When an accepted request has both adder inputs with bit 14 clear and a result with bit 14 set, `ovf_count` is one higher in the cycle after acceptance.
- R4: When an accepted request has both adder inputs with bit 14 set and a result with bit 14 clear (negative overflow), `ovf_count` does not change.
- R5: An accepted request with no overflow leaves `ovf_count` unchanged.
- R6: `ovf_count` is 15 bits wide and wraps from 0x7FFF to 0 on the next positive overflow.
- R7: While `rst_n` is low, `ovf_count` is 0, `res_acc` is 0 and `res_valid` is 0. After reset, `req_ready` is 1.
- R8: `req_ready` is high exactly when `res_valid` is low or `res_ready` is high. While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_acc` holds its value.
- R9: A request presented while `req_ready` is 0 is not taken. It changes neither `res_acc` nor `ovf_count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_sub | input | 1 | 0 = add, 1 = subtract |
| req_acc | input | 15 | Accumulator value (ones' complement) |
| req_opnd | input | 15 | Operand word (ones' complement) |
| res_valid | output | 1 | Result register holds a value |
| res_ready | input | 1 | Downstream takes the result |
| res_acc | output | 15 | New accumulator value |
| ovf_count | output | 15 | Positive-overflow tally, wrapping |

## Verification
The tally wrap is the hardest state to reach. It needs 32768 positive overflows, so the bench streams one overflowing add per cycle with the output always drained, then checks the count at 0x7FFF and again at 0. A second hard case is a request that would overflow while the output is stalled. The bench first fills the result register, drops `res_ready` and presents that request. It confirms that neither the result nor the tally moves, and only then releases the stall.

// File: rtl/oc_arith_pkg.sv
package oc_arith_pkg;
  localparam int unsigned WORD_W = 15;
  localparam int unsigned TALLY_W = 15;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } oc_op_e;
endpackage

// File: rtl/oc_operand_rail.sv
// Selects the true or the complemented rail of the operand register.
module oc_operand_rail #(
  parameter int unsigned W = 15
) (
  input  logic         sel_cmp,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] rail
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rail[i] = sel_cmp ? ~opnd[i] : opnd[i];
  end
endmodule

// File: rtl/oc_eac_adder.sv
// Ones'-complement adder with end-around carry and positive-overflow flag.
module oc_eac_adder #(
  parameter int unsigned W = 15
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         pos_ovf
);
  localparam int unsigned SIGN = W - 1;

  logic [W:0]   raw;
  logic [W-1:0] eac;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    eac = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end

  assign sum     = eac;
  assign pos_ovf = ~a[SIGN] & ~b[SIGN] & eac[SIGN];
endmodule

// File: rtl/oc_ovf_tally.sv
// Wrapping counter of positive overflows.
module oc_ovf_tally #(
  parameter int unsigned CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (bump) begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/oc_accum_unit.sv
module oc_accum_unit
  import oc_arith_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned CW = TALLY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_sub,
  input  logic [W-1:0]  req_acc,
  input  logic [W-1:0]  req_opnd,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [W-1:0]  res_acc,
  output logic [CW-1:0] ovf_count
);
  oc_op_e       op;
  logic [W-1:0] b_rail;
  logic [W-1:0] sum;
  logic         pos_ovf;
  logic         take;
  logic         valid_q;
  logic [W-1:0] acc_q;

  assign op        = oc_op_e'(req_sub);
  assign req_ready = ~valid_q | res_ready;
  assign take      = req_valid & req_ready;

  oc_operand_rail #(.W(W)) u_rail (
    .sel_cmp (op == OP_SUB),
    .opnd    (req_opnd),
    .rail    (b_rail)
  );

  oc_eac_adder #(.W(W)) u_add (
    .a       (req_acc),
    .b       (b_rail),
    .sum     (sum),
    .pos_ovf (pos_ovf)
  );

  oc_ovf_tally #(.CW(CW)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (take & pos_ovf),
    .count (ovf_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      acc_q   <= '0;
    end else if (req_ready) begin
      valid_q <= req_valid;
      if (take) begin
        acc_q <= sum;
      end
    end
  end

  assign res_valid = valid_q;
  assign res_acc   = acc_q;
endmodule

// File: rtl/oc_accum_unit_chk.sv
module oc_accum_unit_chk #(
  parameter int unsigned W  = 15,
  parameter int unsigned CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_sub,
  input logic [W-1:0]  req_acc,
  input logic [W-1:0]  req_opnd,
  input logic          res_valid,
  input logic          res_ready,
  input logic [W-1:0]  res_acc,
  input logic [CW-1:0] ovf_count
);
  function automatic logic [W-1:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[W-1:0] + {{(W-1){1'b0}}, s[W]};
  endfunction

  logic         acc_take;
  logic [W-1:0] eff_b;
  logic [W-1:0] ref_sum;
  logic         ref_pos;

  always_comb begin
    acc_take = req_valid & req_ready;
    eff_b    = req_sub ? ~req_opnd : req_opnd;
    ref_sum  = ref_add(req_acc, eff_b);
    ref_pos  = ~req_acc[W-1] & ~eff_b[W-1] & ref_sum[W-1];
  end

  p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take && !req_sub |=> res_acc == ref_add($past(req_acc), $past(req_opnd)));

  p_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take && req_sub |=> res_acc == ref_add($past(req_acc), ~$past(req_opnd)));

  p_tally_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take && ref_pos |=> ovf_count == $past(ovf_count) + CW'(1));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take && !ref_pos |=> $stable(ovf_count));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_acc));

  p_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_take |=> $stable(ovf_count) && $stable(res_acc));
endmodule

bind oc_accum_unit oc_accum_unit_chk #(.W(W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_sub   (req_sub),
  .req_acc   (req_acc),
  .req_opnd  (req_opnd),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_acc   (res_acc),
  .ovf_count (ovf_count)
);

// File: tb/oc_accum_unit_bench.sv
module oc_accum_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_sub = 1'b0;
  logic [14:0] req_acc = '0;
  logic [14:0] req_opnd = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [14:0] res_acc;
  logic [14:0] ovf_count;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  oc_accum_unit u_oc_accum_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_sub   (req_sub),
    .req_acc   (req_acc),
    .req_opnd  (req_opnd),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_acc   (res_acc),
    .ovf_count (ovf_count)
  );

  // {sub, acc, opnd, expected result, positive overflow}
  localparam int NV = 12;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 15'h0001, 15'h0002, 15'h0003, 1'b0},
    {1'b0, 15'h3FFF, 15'h0001, 15'h4000, 1'b1},
    {1'b0, 15'h7FFE, 15'h7FFE, 15'h7FFD, 1'b0},
    {1'b0, 15'h4000, 15'h4000, 15'h0001, 1'b0},
    {1'b1, 15'h0005, 15'h0003, 15'h0002, 1'b0},
    {1'b1, 15'h0003, 15'h0005, 15'h7FFD, 1'b0},
    {1'b1, 15'h3FFF, 15'h7FFE, 15'h4000, 1'b1},
    {1'b1, 15'h4000, 15'h0001, 15'h3FFF, 1'b0},
    {1'b0, 15'h0001, 15'h7FFE, 15'h7FFF, 1'b0},
    {1'b1, 15'h0000, 15'h0000, 15'h7FFF, 1'b0},
    {1'b0, 15'h2000, 15'h2000, 15'h4000, 1'b1},
    {1'b0, 15'h1234, 15'h0ABC, 15'h1CF0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [14:0] exp_cnt;
    logic [14:0] held;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(ovf_count == 15'h0, "R7 count", int'(ovf_count), 0);
    check(res_valid == 1'b0 && res_acc == 15'h0, "R7 result", int'(res_acc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready", int'(req_ready), 1);

    exp_cnt = '0;
    for (int i = 0; i < NV; i++) begin
      req_sub   = VEC[i][46];
      req_acc   = VEC[i][45:31];
      req_opnd  = VEC[i][30:16];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      exp_cnt = exp_cnt + {14'h0, VEC[i][0]};
      // R1/R2 result, R3/R4/R5 tally
      check(res_acc == VEC[i][15:1] && res_valid,
            VEC[i][46] ? "R2 sub result" : "R1 add result", int'(res_acc), int'(VEC[i][15:1]));
      check(ovf_count == exp_cnt,
            VEC[i][0] ? "R3 tally step" : "R4/R5 tally hold", int'(ovf_count), int'(exp_cnt));
    end

    // R8/R9: stall with an overflowing request waiting
    @(negedge clk);
    req_sub = 1'b0; req_acc = 15'h0007; req_opnd = 15'h0001; req_valid = 1'b1;
    @(negedge clk);
    held = res_acc;
    check(held == 15'h0008, "R1 fill", int'(held), 8);
    res_ready = 1'b0;
    req_acc = 15'h2000; req_opnd = 15'h2000;
    #0;
    check(req_ready == 1'b0, "R8 ready low", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    check(res_valid == 1'b1 && res_acc == held, "R8 hold", int'(res_acc), int'(held));
    check(ovf_count == exp_cnt, "R9 refused tally", int'(ovf_count), int'(exp_cnt));
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_cnt = exp_cnt + 15'h1;
    check(res_acc == 15'h4000, "R9 released result", int'(res_acc), 'h4000);
    check(ovf_count == exp_cnt, "R3 released tally", int'(ovf_count), int'(exp_cnt));

    // R6: wrap of the tally
    rst_n = 1'b0;
    @(negedge clk);
    check(ovf_count == 15'h0, "R7 second reset", int'(ovf_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    req_sub = 1'b0; req_acc = 15'h0001; req_opnd = 15'h3FFF; req_valid = 1'b1;
    repeat (32767) @(posedge clk);
    @(negedge clk);
    check(ovf_count == 15'h7FFF, "R6 top", int'(ovf_count), 'h7FFF);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(ovf_count == 15'h0, "R6 wrap", int'(ovf_count), 0);

    finish_run();
  end
endmodule